// File: doc/BRIEF.md
# CCD Line and Field Timing Generator

This block turns a continuous pixel clock into the line and period timebase that drives an interline CCD area sensor. A pixel counter wraps once per line and advances a line counter, which wraps once per period. The period length depends on the accumulation mode. In monitoring mode (field accumulation), each period holds two interlaced fields, so a second vertical strobe falls halfway through the period, in the middle of a line. In still-capture mode (frame accumulation), periods are longer and the sensor is read out in two interleaved passes.

From these counts the block decodes the following outputs:
- a horizontal strobe once per line;
- a vertical strobe at the start of each period (and at mid-period in monitoring mode);
- two readout-gate windows at fixed pixel positions;
- the overflow-drain control level;
- an electronic-shutter pulse for each field in monitoring mode;
- a charge-sweep window in still-capture mode;
- an exposure-permit level that opens only after the drain control has settled.

Mode requests are taken only at the period boundary. The first image after any switch is flagged not valid.

Top module: `ccd_tgen`

## Requirements
- R1: While reset is asserted and right after it, pix_o is 0, line_o is 1, mode_o is 0 (field), valid_o is 0 and ofdc_o is 0.
- R2: pix_o counts 0 to PIX_PER_LINE-1 and wraps. line_o advances by one on each wrap and runs 1 to the period total. The total is FIELD_LINES when mode_o is 0 and FRAME_LINES when mode_o is 1. After the total, line_o returns to 1.
- R3: hd_o is high for exactly the cycles with pix_o equal to 0.
- R4: vd_o is high at line 1, pixel 0 in both modes. In field mode only, it is also high at line FIELD_LINES/2 (rounded down), pixel PIX_PER_LINE/2. It is low at every other position.
- R5: mode_req_i (0 = field, 1 = frame) is sampled only in the last cycle of a period (last pixel of the last line). mode_o takes the sampled value in the next cycle, and changes at no other time.
- R6: valid_o is updated only at the start of a period. It goes to 1 if the sampled request equals the current mode and to 0 if it differs. It stays 0 throughout the first period after reset.
- R7: ro_a_o is high on line 1 for pixels RO_A_START to RO_A_START+RO_WIDTH-1, in both modes.
- R8: ro_b_o is high for pixels RO_B_START to RO_B_START+RO_WIDTH-1. In field mode this is on line 1; in frame mode it is on line 2.
- R9: ofdc_o equals mode_o: low in field mode, high in frame mode.
- R10: expo_ok_o is high only in frame mode, only after ofdc_o has been high for SETTLE_CYC cycles in a row, and never while sweep_o is high.
- R11: sweep_o is high in frame mode for lines SWEEP_START to SWEEP_START+SWEEP_LINES-1, and always low in field mode.
- R12: shut_o is high in field mode only, for pixels SHUT_PIX to SHUT_PIX+SHUT_WIDTH-1. It fires on line SHUT_LINE and on line SHUT_LINE+FIELD_LINES/2, giving one pulse per field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_req_i | input | 1 | Requested mode: 0 field, 1 frame |
| pix_o | output | PW | Pixel position within the line |
| line_o | output | LW | Line number within the period, from 1 |
| mode_o | output | 1 | Active mode |
| hd_o | output | 1 | Line strobe |
| vd_o | output | 1 | Vertical strobe |
| ro_a_o | output | 1 | First readout-gate window |
| ro_b_o | output | 1 | Second readout-gate window |
| valid_o | output | 1 | Current image is usable |
| ofdc_o | output | 1 | Overflow-drain control level |
| shut_o | output | 1 | Electronic-shutter pulse |
| sweep_o | output | 1 | Charge-sweep window |
| expo_ok_o | output | 1 | Exposure permitted |

## Verification
Several properties are checked on every cycle:
- the pixel wrap and the line step;
- the alignment of the line strobe;
- mode changes happening only at the period boundary;
- valid_o being low in the cycle a mode switch takes effect;
- the width of each readout window;
- the exclusion between sweep and exposure permit;
- the settle time before exposure opens;
- shutter pulses never appearing in frame mode.

Other behaviours are shown only by the bench's scenarios:
- the exact position of the mid-period strobe;
- the line chosen for each readout window in each mode;
- the recovery of valid_o one period after a switch;
- requests that toggle and return inside a period;
- a request that lands in the boundary cycle itself.

// File: rtl/ccd_tgen_pkg.sv
package ccd_tgen_pkg;
  typedef enum logic {
    ACC_FIELD = 1'b0,
    ACC_FRAME = 1'b1
  } acc_mode_e;

  function automatic int maxi(int a, int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/ccd_tgen_cnt.sv
module ccd_tgen_cnt
  import ccd_tgen_pkg::*;
#(
  parameter int PIX_PER_LINE = 2640,
  parameter int FIELD_LINES  = 455,
  parameter int FRAME_LINES  = 848,
  parameter int PW           = 12,
  parameter int LW           = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_req_i,
  output logic [PW-1:0] pix_o,
  output logic [LW-1:0] line_o,
  output acc_mode_e     mode_o,
  output logic          valid_o
);
  logic [PW-1:0] pix_q;
  logic [LW-1:0] line_q;
  acc_mode_e     mode_q;
  logic          valid_q;
  logic          line_end, period_end;
  logic [LW-1:0] last_line;
  acc_mode_e     req_mode;

  assign req_mode   = acc_mode_e'(mode_req_i);
  assign last_line  = (mode_q == ACC_FRAME) ? LW'(FRAME_LINES) : LW'(FIELD_LINES);
  assign line_end   = (pix_q == PW'(PIX_PER_LINE - 1));
  assign period_end = line_end && (line_q == last_line);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_q   <= '0;
      line_q  <= LW'(1);
      mode_q  <= ACC_FIELD;
      valid_q <= 1'b0;
    end else begin
      pix_q <= line_end ? '0 : pix_q + 1'b1;
      if (line_end) line_q <= period_end ? LW'(1) : line_q + 1'b1;
      // request is taken only at the period boundary
      if (period_end) begin
        mode_q  <= req_mode;
        valid_q <= (req_mode == mode_q);
      end
    end
  end

  assign pix_o   = pix_q;
  assign line_o  = line_q;
  assign mode_o  = mode_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/ccd_tgen_hv.sv
module ccd_tgen_hv
  import ccd_tgen_pkg::*;
#(
  parameter int PIX_PER_LINE = 2640,
  parameter int FIELD_LINES  = 455,
  parameter int RO_WIDTH     = 126,
  parameter int RO_A_START   = 698,
  parameter int RO_B_START   = 1034,
  parameter int PW           = 12,
  parameter int LW           = 10
) (
  input  logic [PW-1:0] pix_i,
  input  logic [LW-1:0] line_i,
  input  acc_mode_e     mode_i,
  output logic          hd_o,
  output logic          vd_o,
  output logic [1:0]    ro_o
);
  localparam int HALF_LINE = FIELD_LINES / 2;
  localparam int HALF_PIX  = PIX_PER_LINE / 2;

  logic vd_top, vd_mid;

  assign hd_o   = (pix_i == '0);
  assign vd_top = (pix_i == '0) && (line_i == LW'(1));
  assign vd_mid = (mode_i == ACC_FIELD) && (line_i == LW'(HALF_LINE))
                  && (pix_i == PW'(HALF_PIX));
  assign vd_o   = vd_top || vd_mid;

  // readout windows: frame mode reads the two passes on consecutive lines
  for (genvar g = 0; g < 2; g++) begin : g_ro
    localparam int START = (g == 0) ? RO_A_START : RO_B_START;
    logic          in_pix;
    logic [LW-1:0] ro_line;
    assign in_pix  = (pix_i >= PW'(START)) && (pix_i < PW'(START + RO_WIDTH));
    assign ro_line = (mode_i == ACC_FRAME) ? LW'(g + 1) : LW'(1);
    assign ro_o[g] = in_pix && (line_i == ro_line);
  end
endmodule

// File: rtl/ccd_tgen_ofd.sv
module ccd_tgen_ofd
  import ccd_tgen_pkg::*;
#(
  parameter int FIELD_LINES = 455,
  parameter int SHUT_LINE   = 2,
  parameter int SHUT_PIX    = 152,
  parameter int SHUT_WIDTH  = 56,
  parameter int SWEEP_START = 2,
  parameter int SWEEP_LINES = 64,
  parameter int SETTLE_CYC  = 180000,
  parameter int PW          = 12,
  parameter int LW          = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] pix_i,
  input  logic [LW-1:0] line_i,
  input  acc_mode_e     mode_i,
  output logic          ofdc_o,
  output logic          shut_o,
  output logic          sweep_o,
  output logic          expo_ok_o
);
  localparam int HALF_LINE = FIELD_LINES / 2;
  localparam int SW        = $clog2(SETTLE_CYC + 1);

  logic [SW-1:0] settle_q;
  logic          settled;
  logic [1:0]    shut_hit;
  logic          shut_pix;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      settle_q <= '0;
    end else if (mode_i == ACC_FRAME) begin
      if (!settled) settle_q <= settle_q + 1'b1;
    end else begin
      settle_q <= '0;
    end
  end

  assign settled  = (settle_q == SW'(SETTLE_CYC));
  assign ofdc_o   = (mode_i == ACC_FRAME);
  assign sweep_o  = (mode_i == ACC_FRAME) && (line_i >= LW'(SWEEP_START))
                    && (line_i < LW'(SWEEP_START + SWEEP_LINES));
  assign expo_ok_o = ofdc_o && settled && !sweep_o;

  // one shutter pulse per field
  assign shut_pix = (pix_i >= PW'(SHUT_PIX)) && (pix_i < PW'(SHUT_PIX + SHUT_WIDTH));
  for (genvar g = 0; g < 2; g++) begin : g_shut
    assign shut_hit[g] = (line_i == LW'(SHUT_LINE + g * HALF_LINE));
  end
  assign shut_o = (mode_i == ACC_FIELD) && shut_pix && (|shut_hit);
endmodule

// File: rtl/ccd_tgen.sv
module ccd_tgen
  import ccd_tgen_pkg::*;
#(
  parameter int PIX_PER_LINE = 2640,
  parameter int FIELD_LINES  = 455,
  parameter int FRAME_LINES  = 848,
  parameter int RO_WIDTH     = 126,
  parameter int RO_A_START   = 698,
  parameter int RO_B_START   = 1034,
  parameter int SHUT_LINE    = 2,
  parameter int SHUT_PIX     = 152,
  parameter int SHUT_WIDTH   = 56,
  parameter int SWEEP_START  = 2,
  parameter int SWEEP_LINES  = 64,
  parameter int SETTLE_CYC   = 180000,
  localparam int PW          = $clog2(PIX_PER_LINE),
  localparam int LW          = $clog2(maxi(FIELD_LINES, FRAME_LINES) + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_req_i,
  output logic [PW-1:0] pix_o,
  output logic [LW-1:0] line_o,
  output logic          mode_o,
  output logic          hd_o,
  output logic          vd_o,
  output logic          ro_a_o,
  output logic          ro_b_o,
  output logic          valid_o,
  output logic          ofdc_o,
  output logic          shut_o,
  output logic          sweep_o,
  output logic          expo_ok_o
);
  acc_mode_e mode;
  logic [1:0] ro;

  ccd_tgen_cnt #(
    .PIX_PER_LINE(PIX_PER_LINE), .FIELD_LINES(FIELD_LINES),
    .FRAME_LINES(FRAME_LINES), .PW(PW), .LW(LW)
  ) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_req_i(mode_req_i),
    .pix_o(pix_o), .line_o(line_o), .mode_o(mode), .valid_o(valid_o)
  );

  ccd_tgen_hv #(
    .PIX_PER_LINE(PIX_PER_LINE), .FIELD_LINES(FIELD_LINES), .RO_WIDTH(RO_WIDTH),
    .RO_A_START(RO_A_START), .RO_B_START(RO_B_START), .PW(PW), .LW(LW)
  ) u_hv (
    .pix_i(pix_o), .line_i(line_o), .mode_i(mode),
    .hd_o(hd_o), .vd_o(vd_o), .ro_o(ro)
  );

  ccd_tgen_ofd #(
    .FIELD_LINES(FIELD_LINES), .SHUT_LINE(SHUT_LINE), .SHUT_PIX(SHUT_PIX),
    .SHUT_WIDTH(SHUT_WIDTH), .SWEEP_START(SWEEP_START), .SWEEP_LINES(SWEEP_LINES),
    .SETTLE_CYC(SETTLE_CYC), .PW(PW), .LW(LW)
  ) u_ofd (
    .clk_i(clk_i), .rst_ni(rst_ni), .pix_i(pix_o), .line_i(line_o), .mode_i(mode),
    .ofdc_o(ofdc_o), .shut_o(shut_o), .sweep_o(sweep_o), .expo_ok_o(expo_ok_o)
  );

  assign mode_o = mode;
  assign ro_a_o = ro[0];
  assign ro_b_o = ro[1];
endmodule

// File: rtl/ccd_tgen_chk.sv
module ccd_tgen_chk #(
  parameter int PIX_PER_LINE = 2640,
  parameter int FIELD_LINES  = 455,
  parameter int FRAME_LINES  = 848,
  parameter int RO_WIDTH     = 126,
  parameter int SETTLE_CYC   = 180000,
  parameter int PW           = 12,
  parameter int LW           = 10
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [PW-1:0] pix_o,
  input logic [LW-1:0] line_o,
  input logic          mode_o,
  input logic          hd_o,
  input logic          ro_a_o,
  input logic          ro_b_o,
  input logic          valid_o,
  input logic          ofdc_o,
  input logic          shut_o,
  input logic          sweep_o,
  input logic          expo_ok_o
);
  logic [LW-1:0] last_line;
  logic          at_end, at_wrap;
  int            run_a, run_b, ofdc_run;

  assign last_line = mode_o ? LW'(FRAME_LINES) : LW'(FIELD_LINES);
  assign at_wrap   = (pix_o == PW'(PIX_PER_LINE - 1));
  assign at_end    = at_wrap && (line_o == last_line);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_a    <= 0;
      run_b    <= 0;
      ofdc_run <= 0;
    end else begin
      run_a <= ro_a_o ? run_a + 1 : 0;
      run_b <= ro_b_o ? run_b + 1 : 0;
      if (!ofdc_o)                  ofdc_run <= 0;
      else if (ofdc_run < SETTLE_CYC) ofdc_run <= ofdc_run + 1;
    end
  end

  a_r2_pix_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    at_wrap |=> pix_o == '0);
  a_r2_line_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (at_wrap && !at_end) |=> line_o == $past(line_o) + 1'b1);
  a_r2_period_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    at_end |=> line_o == LW'(1));
  a_r3_hd_pix0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hd_o |-> pix_o == '0);
  a_r5_mode_at_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !at_end |=> $stable(mode_o));
  a_r6_switch_invalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o != $past(mode_o)) |-> !valid_o);
  a_r7_ro_a_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ro_a_o) |-> run_a == RO_WIDTH);
  a_r8_ro_b_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ro_b_o) |-> run_b == RO_WIDTH);
  a_r10_no_expo_in_sweep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(expo_ok_o && sweep_o));
  a_r10_settled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(expo_ok_o) |-> ofdc_run >= SETTLE_CYC);
  a_r12_shut_field_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shut_o |-> !ofdc_o);
endmodule

bind ccd_tgen ccd_tgen_chk #(
  .PIX_PER_LINE(PIX_PER_LINE), .FIELD_LINES(FIELD_LINES), .FRAME_LINES(FRAME_LINES),
  .RO_WIDTH(RO_WIDTH), .SETTLE_CYC(SETTLE_CYC), .PW(PW), .LW(LW)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pix_o(pix_o), .line_o(line_o), .mode_o(mode_o),
  .hd_o(hd_o), .ro_a_o(ro_a_o), .ro_b_o(ro_b_o), .valid_o(valid_o), .ofdc_o(ofdc_o),
  .shut_o(shut_o), .sweep_o(sweep_o), .expo_ok_o(expo_ok_o)
);

// File: tb/ccd_tgen_tb.sv
`timescale 1ns/1ps
module ccd_tgen_tb;
  localparam int P   = 40;
  localparam int FL  = 11;
  localparam int FR  = 14;
  localparam int RW  = 4;
  localparam int RA  = 8;
  localparam int RB  = 20;
  localparam int SL  = 2;
  localparam int SP  = 5;
  localparam int SWD = 6;
  localparam int SS  = 3;
  localparam int SN  = 4;
  localparam int ST  = 100;
  localparam int PW  = $clog2(P);
  localparam int LW  = $clog2(FR + 1);
  localparam int HL  = FL / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic [PW-1:0] pix;
  logic [LW-1:0] line;
  logic mode, hd, vd, ro_a, ro_b, valid, ofdc, shut, sweep, expo;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  // reference state
  int m_pix, m_line, m_mode, m_valid, m_settle;

  always #10 clk = ~clk;

  ccd_tgen #(
    .PIX_PER_LINE(P), .FIELD_LINES(FL), .FRAME_LINES(FR), .RO_WIDTH(RW),
    .RO_A_START(RA), .RO_B_START(RB), .SHUT_LINE(SL), .SHUT_PIX(SP),
    .SHUT_WIDTH(SWD), .SWEEP_START(SS), .SWEEP_LINES(SN), .SETTLE_CYC(ST)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_req_i(req), .pix_o(pix), .line_o(line),
    .mode_o(mode), .hd_o(hd), .vd_o(vd), .ro_a_o(ro_a), .ro_b_o(ro_b),
    .valid_o(valid), .ofdc_o(ofdc), .shut_o(shut), .sweep_o(sweep), .expo_ok_o(expo)
  );

  function automatic int tot(int md);
    return md ? FR : FL;
  endfunction

  function automatic bit at_end();
    return (m_pix == P - 1) && (m_line == tot(m_mode));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pix <= 0; m_line <= 1; m_mode <= 0; m_valid <= 0; m_settle <= 0;
    end else begin
      m_pix <= (m_pix == P - 1) ? 0 : m_pix + 1;
      if (m_pix == P - 1) m_line <= at_end() ? 1 : m_line + 1;
      if (at_end()) begin
        m_mode  <= int'(req);
        m_valid <= (int'(req) == m_mode) ? 1 : 0;
      end
      if (m_mode == 1) m_settle <= (m_settle < ST) ? m_settle + 1 : ST;
      else             m_settle <= 0;
    end
  end

  task automatic chk(bit ok, string req_tag, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d (line %0d pix %0d)", req_tag, act, exp, m_line, m_pix);
    end
  endtask

  function automatic bit in_rng(int v, int lo, int n);
    return (v >= lo) && (v < lo + n);
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit e_vd, e_ra, e_rb, e_sh, e_sw, e_ex;
      e_vd = (m_pix == 0 && m_line == 1) || (m_mode == 0 && m_line == HL && m_pix == P / 2);
      e_ra = (m_line == 1) && in_rng(m_pix, RA, RW);
      e_rb = (m_line == (m_mode ? 2 : 1)) && in_rng(m_pix, RB, RW);
      e_sh = (m_mode == 0) && (m_line == SL || m_line == SL + HL) && in_rng(m_pix, SP, SWD);
      e_sw = (m_mode == 1) && in_rng(m_line, SS, SN);
      e_ex = (m_mode == 1) && (m_settle == ST) && !e_sw;
      chk(int'(pix) == m_pix,   "R2 pix",   int'(pix), m_pix);
      chk(int'(line) == m_line, "R2 line",  int'(line), m_line);
      chk(hd == (m_pix == 0),   "R3 hd",    int'(hd), int'(m_pix == 0));
      chk(vd == e_vd,           "R4 vd",    int'(vd), int'(e_vd));
      chk(int'(mode) == m_mode, "R5 mode",  int'(mode), m_mode);
      chk(int'(valid) == m_valid, "R6 valid", int'(valid), m_valid);
      chk(ro_a == e_ra,         "R7 ro_a",  int'(ro_a), int'(e_ra));
      chk(ro_b == e_rb,         "R8 ro_b",  int'(ro_b), int'(e_rb));
      chk(int'(ofdc) == m_mode, "R9 ofdc",  int'(ofdc), m_mode);
      chk(expo == e_ex,         "R10 expo", int'(expo), int'(e_ex));
      chk(sweep == e_sw,        "R11 sweep", int'(sweep), int'(e_sw));
      chk(shut == e_sh,         "R12 shut", int'(shut), int'(e_sh));
    end
  end

  task automatic run(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_end();
    @(negedge clk);
    while (!at_end()) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    run(3);
    // R1 reset values
    chk(pix == '0,       "R1 pix",   int'(pix), 0);
    chk(line == LW'(1),  "R1 line",  int'(line), 1);
    chk(mode == 1'b0,    "R1 mode",  int'(mode), 0);
    chk(valid == 1'b0,   "R1 valid", int'(valid), 0);
    chk(ofdc == 1'b0,    "R1 ofdc",  int'(ofdc), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pix == PW'(1) && line == LW'(1) && !valid, "R1 after release", int'(pix), 1);
    // field periods, then switch to frame requested early
    run(3 * P * FL);
    req = 1'b1;
    run(5 * P * FR);
    // back to field, request arriving in the boundary cycle itself
    wait_end();
    req = 1'b0;
    run(2 * P * FL + 7);
    // short glitch of the request inside a period: no change (R5)
    run(P * 2);
    req = 1'b1;
    run(P * 3);
    req = 1'b0;
    run(2 * P * FL);
    // random request activity
    for (int i = 0; i < 9000; i++) begin
      @(negedge clk);
      if ($urandom_range(0, 399) == 0) req = ~req;
    end
    finish_run();
  end

  initial begin
    #(20 * 60000);
    tests++;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule